// File: doc/BRIEF.md
# Width-Configurable Ternary Match Array

This block is a small ternary content-addressable store. Its storage is a row of 72-bit segments. Each segment holds a data word, a local mask word and a valid bit. A width-configuration register regroups the segments at run time into entries of one, two or four segments, so a single physical array serves as 72-, 144- or 288-bit entries. As the entries grow wider, their count falls by the same factor.

A controller drives one request per cycle on a single request port. The request can be:

- a write or read of the data words, the mask words or a small register space (width configuration, next-free pointer, global masks);
- a search;
- a learn.

A search compares a key of up to 288 bits against every entry. It applies one selected global mask together with each segment's local mask. It returns a hit flag and the index of the lowest matching entry, and it also copies the key into one of the comparand slots. A learn copies a slot's key into the entry at the next-free pointer and then advances the pointer.

Top module: `ternary_match_array`

## Requirements
- R1: After reset every valid bit is clear, so no search hits. The width register reads 0x0000, the next-free pointer reads 0, every global mask reads all ones, and rd_valid, srch_valid, learn_done and learn_err are low.
- R2: Requests use req_op 0 = write, 1 = read, 2 = search, 3 = learn. They use req_space 0 = data, 1 = local mask, 2 = register. A write stores req_wdata at segment req_addr. A read returns the word on rd_data with rd_valid high one cycle after the request. A data write sets that segment's valid bit.
- R3: In the register space, address 0 is the width register (16 bits, in rd_data[15:0]) and address 1 is the next-free pointer. Address 2+g is global mask g. All of them can be written and read back.
- R4: A width value of 0x0000 gives 1-segment entries, 0x5555 gives 2-segment entries and 0xAAAA gives 4-segment entries. Any other value behaves as 1-segment.
- R5: A key bit takes part in the compare only if both the selected global mask bit (req_gm_sel) and the segment's local mask bit are 1. The segment at offset p inside its entry compares against key bits [72*p +: 72].
- R6: A k-segment entry starts at a segment address that is a multiple of k. It matches only when all k segments match in their own key lanes.
- R7: srch_valid rises exactly two cycles after a search request. srch_hit is 0 when nothing matches. Otherwise srch_index is the lowest matching entry, that is, its first segment address divided by k.
- R8: A segment whose valid bit is clear never matches, whatever it holds. A mask write alone does not set the valid bit.
- R9: Every search stores its key in comparand slot req_slot (0..15). A later learn naming that slot uses exactly that key.
- R10: A learn from slot req_slot writes the slot's key lanes into the k segments starting at the next-free pointer. It sets their local masks to all ones and marks them valid. It pulses learn_done one cycle later and advances the pointer by k.
- R11: A learn for which pointer + k exceeds the segment count writes nothing and leaves the pointer unchanged. It pulses learn_err one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | 0 write, 1 read, 2 search, 3 learn |
| req_space | input | 2 | 0 data, 1 local mask, 2 register |
| req_addr | input | 4 | Segment or register address |
| req_wdata | input | 72 | Write word |
| req_key | input | 288 | Search key, lane p in bits [72*p +: 72] |
| req_gm_sel | input | 2 | Global mask selector for a search |
| req_slot | input | 4 | Comparand slot for search or learn |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 72 | Read data |
| srch_valid | output | 1 | Search result valid |
| srch_hit | output | 1 | At least one entry matched |
| srch_index | output | 4 | Lowest matching entry index |
| learn_done | output | 1 | Learn accepted |
| learn_err | output | 1 | Learn rejected, array full |

## Verification
The assertions assume three things about the controller. It does not change the width register while a search is still in its two-cycle pipeline. It keeps the next-free pointer aligned to the entry size. It writes the pointer only through learn or reset, so each learn advance can be checked against the previous value. The bench issues every request with an idle cycle after it and waits for each search result before the next request. It changes the width only between complete searches, and it exercises learn only from a reset pointer at a fixed width. Expected indices, lanes and pointer values come from plain arithmetic on the segment address and the entry size.

// File: rtl/tma_pkg.sv
package tma_pkg;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_SEARCH = 2'd2,
    OP_LEARN  = 2'd3
  } tma_op_e;

  typedef enum logic [1:0] {
    SP_DATA = 2'd0,
    SP_MASK = 2'd1,
    SP_REG  = 2'd2,
    SP_NONE = 2'd3
  } tma_space_e;

  localparam logic [15:0] WIDTH_X1 = 16'h0000;
  localparam logic [15:0] WIDTH_X2 = 16'h5555;
  localparam logic [15:0] WIDTH_X4 = 16'hAAAA;

  localparam int REG_WIDTH = 0;
  localparam int REG_NEXT  = 1;
  localparam int REG_GM0   = 2;

  // log2 of segments per entry
  function automatic logic [1:0] width_shift(input logic [15:0] cfg);
    case (cfg)
      WIDTH_X2: return 2'd1;
      WIDTH_X4: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] seg_per_entry(input logic [1:0] sh);
    return 3'd1 << sh;
  endfunction

  // key lane a segment compares against: its offset inside the entry
  function automatic logic [1:0] key_lane(input logic [1:0] seg_lo, input logic [1:0] sh);
    case (sh)
      2'd0:    return 2'd0;
      2'd1:    return {1'b0, seg_lo[0]};
      default: return seg_lo;
    endcase
  endfunction

endpackage

// File: rtl/tma_ctrl_regs.sv
module tma_ctrl_regs
  import tma_pkg::*;
#(
  parameter int SEG_W    = 72,
  parameter int NUM_SEG  = 16,
  parameter int NUM_GM   = 4,
  parameter int NUM_SLOT = 16,
  parameter int ADDR_W   = 4,
  parameter int NFA_W    = 5,
  parameter int GSEL_W   = 2,
  parameter int SLOT_W   = 4,
  parameter int KEY_W    = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEG_W-1:0]  req_wdata,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [GSEL_W-1:0] req_gm_sel,
  input  logic [SLOT_W-1:0] req_slot,
  output logic [1:0]        width_sh,
  output logic [SEG_W-1:0]  srch_gmask,
  output logic              learn_en,
  output logic [ADDR_W-1:0] learn_base,
  output logic [KEY_W-1:0]  learn_key,
  output logic              learn_done,
  output logic              learn_err,
  output logic [SEG_W-1:0]  reg_rdata
);

  localparam int SUM_W = NFA_W + 1;

  logic [15:0]      width_q;
  logic [NFA_W-1:0] next_q;
  logic [SEG_W-1:0] gm_q   [NUM_GM];
  logic [KEY_W-1:0] slot_q [NUM_SLOT];

  logic             reg_wr, learn_req, search_req;
  logic [2:0]       nseg;
  logic [SUM_W-1:0] next_sum;

  assign reg_wr     = req_valid && req_op == OP_WRITE && req_space == SP_REG;
  assign learn_req  = req_valid && req_op == OP_LEARN;
  assign search_req = req_valid && req_op == OP_SEARCH;

  assign width_sh = width_shift(width_q);
  assign nseg     = seg_per_entry(width_sh);
  assign next_sum = SUM_W'(next_q) + SUM_W'(nseg);

  assign learn_en   = learn_req && (next_sum <= SUM_W'(NUM_SEG));
  assign learn_base = next_q[ADDR_W-1:0];
  assign learn_key  = slot_q[req_slot];
  assign srch_gmask = gm_q[req_gm_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q    <= WIDTH_X1;
      next_q     <= '0;
      learn_done <= 1'b0;
      learn_err  <= 1'b0;
    end else begin
      learn_done <= learn_en;
      learn_err  <= learn_req && !learn_en;
      if (reg_wr && req_addr == ADDR_W'(REG_WIDTH)) width_q <= req_wdata[15:0];
      if (reg_wr && req_addr == ADDR_W'(REG_NEXT)) next_q <= req_wdata[NFA_W-1:0];
      else if (learn_en) next_q <= next_sum[NFA_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GM; g++) begin : g_gm
    always_ff @(posedge clk) begin
      if (!rst_n) gm_q[g] <= '1;
      else if (reg_wr && req_addr == ADDR_W'(REG_GM0 + g)) gm_q[g] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (search_req) slot_q[req_slot] <= req_key;
  end

  always_comb begin
    reg_rdata = '0;
    if (req_addr == ADDR_W'(REG_WIDTH)) reg_rdata[15:0] = width_q;
    else if (req_addr == ADDR_W'(REG_NEXT)) reg_rdata[NFA_W-1:0] = next_q;
    else begin
      for (int g = 0; g < NUM_GM; g++)
        if (req_addr == ADDR_W'(REG_GM0 + g)) reg_rdata = gm_q[g];
    end
  end

  // R10: an accepted learn moves the pointer by exactly one entry
  a_r10_next_advances: assert property (@(posedge clk) disable iff (!rst_n)
    learn_done |-> next_q == NFA_W'($past(next_q) + NFA_W'($past(nseg))));
  // R11: a rejected learn leaves the pointer alone
  a_r11_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    learn_err |-> $stable(next_q));
  // R10/R11: accept and reject never pulse together
  a_r11_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(learn_done && learn_err));

endmodule

// File: rtl/tma_seg_store.sv
module tma_seg_store
  import tma_pkg::*;
#(
  parameter int SEG_W   = 72,
  parameter int NUM_SEG = 16,
  parameter int ADDR_W  = 4,
  parameter int KEY_W   = 288
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_data_en,
  input  logic               wr_mask_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SEG_W-1:0]   wr_word,
  input  logic               learn_en,
  input  logic [ADDR_W-1:0]  learn_base,
  input  logic [KEY_W-1:0]   learn_key,
  input  logic [1:0]         width_sh,
  input  logic               rd_mask_sel,
  output logic [SEG_W-1:0]   rd_word,
  input  logic               srch_en,
  input  logic [KEY_W-1:0]   srch_key,
  input  logic [SEG_W-1:0]   srch_gmask,
  output logic [NUM_SEG-1:0] seg_hit_q,
  output logic               seg_hit_vld
);

  logic [SEG_W-1:0]   data_q [NUM_SEG];
  logic [SEG_W-1:0]   mask_q [NUM_SEG];
  logic [NUM_SEG-1:0] valid_q;

  logic [NUM_SEG-1:0] lrn_sel, cmp_hit;
  logic [1:0]         lrn_lane [NUM_SEG];
  logic [2:0]         nseg;

  assign nseg = seg_per_entry(width_sh);

  function automatic logic seg_match(input logic [SEG_W-1:0] d, input logic [SEG_W-1:0] lm,
                                     input logic [SEG_W-1:0] gm, input logic [SEG_W-1:0] k);
    return ((d ^ k) & lm & gm) == '0;
  endfunction

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_seg
    logic [ADDR_W:0] rel;
    logic [1:0]      lane;
    assign rel         = (ADDR_W+1)'(j) - {1'b0, learn_base};
    assign lrn_sel[j]  = learn_en && ((ADDR_W+1)'(j) >= {1'b0, learn_base}) &&
                         (rel < (ADDR_W+1)'(nseg));
    assign lrn_lane[j] = rel[1:0];
    assign lane        = key_lane(2'(j), width_sh);
    assign cmp_hit[j]  = valid_q[j] &&
                         seg_match(data_q[j], mask_q[j], srch_gmask, srch_key[SEG_W*lane +: SEG_W]);
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < NUM_SEG; j++) begin
      if (wr_data_en && wr_addr == ADDR_W'(j)) data_q[j] <= wr_word;
      else if (lrn_sel[j]) data_q[j] <= learn_key[SEG_W*lrn_lane[j] +: SEG_W];
      if (wr_mask_en && wr_addr == ADDR_W'(j)) mask_q[j] <= wr_word;
      else if (lrn_sel[j]) mask_q[j] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      seg_hit_q   <= '0;
      seg_hit_vld <= 1'b0;
    end else begin
      for (int j = 0; j < NUM_SEG; j++)
        if ((wr_data_en && wr_addr == ADDR_W'(j)) || lrn_sel[j]) valid_q[j] <= 1'b1;
      seg_hit_vld <= srch_en;
      seg_hit_q   <= srch_en ? cmp_hit : '0;
    end
  end

  assign rd_word = rd_mask_sel ? mask_q[wr_addr] : data_q[wr_addr];

  // R2: a data write leaves its segment valid
  a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> valid_q[$past(wr_addr)]);
  // R8: no registered segment hit on a segment that was invalid when searched
  a_r8_invalid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    seg_hit_vld |-> (seg_hit_q & ~$past(valid_q)) == '0);
  // R10: learn touches at most one entry of segments
  a_r10_learn_span: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lrn_sel) <= 4);

endmodule

// File: rtl/tma_match_resolve.sv
module tma_match_resolve #(
  parameter int NUM_SEG = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEG-1:0] seg_hit,
  input  logic               seg_vld,
  input  logic [1:0]         width_sh,
  output logic               srch_valid,
  output logic               srch_hit,
  output logic [ADDR_W-1:0]  srch_index
);

  logic [NUM_SEG-1:0] ent_hit;
  logic               first_hit;
  logic [ADDR_W-1:0]  first_seg;

  for (genvar j = 0; j < NUM_SEG; j++) begin : g_ent
    logic h2, h4;
    if ((j % 2 == 0) && (j + 1 < NUM_SEG)) begin : g_h2
      assign h2 = &seg_hit[j +: 2];
    end else begin : g_n2
      assign h2 = 1'b0;
    end
    if ((j % 4 == 0) && (j + 3 < NUM_SEG)) begin : g_h4
      assign h4 = &seg_hit[j +: 4];
    end else begin : g_n4
      assign h4 = 1'b0;
    end
    assign ent_hit[j] = (width_sh == 2'd0) ? seg_hit[j] :
                        (width_sh == 2'd1) ? h2 : h4;
  end

  always_comb begin
    first_hit = 1'b0;
    first_seg = '0;
    for (int j = NUM_SEG - 1; j >= 0; j--) begin
      if (ent_hit[j]) begin
        first_hit = 1'b1;
        first_seg = ADDR_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srch_valid <= 1'b0;
      srch_hit   <= 1'b0;
      srch_index <= '0;
    end else begin
      srch_valid <= seg_vld;
      srch_hit   <= seg_vld && first_hit;
      srch_index <= (seg_vld && first_hit) ? (first_seg >> width_sh) : '0;
    end
  end

  // R7: a hit only comes with a valid result
  a_r7_hit_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> srch_valid);
  // R7: the reported entry exists at the current width
  a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && srch_hit) |-> (int'(srch_index) < (NUM_SEG >> width_sh)));
  // R6: the chosen base segment is aligned to the entry size
  a_r6_aligned_base: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_vld && first_hit) |-> ((first_seg & ADDR_W'((1 << width_sh) - 1)) == '0));

endmodule

// File: rtl/ternary_match_array.sv
module ternary_match_array
  import tma_pkg::*;
#(
  parameter int SEG_W    = 72,
  parameter int NUM_SEG  = 16,
  parameter int NUM_GM   = 4,
  parameter int NUM_SLOT = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [1:0]                req_space,
  input  logic [$clog2(NUM_SEG)-1:0] req_addr,
  input  logic [SEG_W-1:0]          req_wdata,
  input  logic [4*SEG_W-1:0]        req_key,
  input  logic [$clog2(NUM_GM)-1:0] req_gm_sel,
  input  logic [$clog2(NUM_SLOT)-1:0] req_slot,
  output logic                      rd_valid,
  output logic [SEG_W-1:0]          rd_data,
  output logic                      srch_valid,
  output logic                      srch_hit,
  output logic [$clog2(NUM_SEG)-1:0] srch_index,
  output logic                      learn_done,
  output logic                      learn_err
);

  localparam int ADDR_W = $clog2(NUM_SEG);
  localparam int NFA_W  = $clog2(NUM_SEG + 1);
  localparam int GSEL_W = $clog2(NUM_GM);
  localparam int SLOT_W = $clog2(NUM_SLOT);
  localparam int KEY_W  = 4 * SEG_W;

  logic               wr_data_en, wr_mask_en, rd_req, srch_en;
  logic [1:0]         width_sh;
  logic [SEG_W-1:0]   srch_gmask, reg_rdata, store_rd;
  logic               learn_en;
  logic [ADDR_W-1:0]  learn_base;
  logic [KEY_W-1:0]   learn_key;
  logic [NUM_SEG-1:0] seg_hit;
  logic               seg_vld;

  assign wr_data_en = req_valid && req_op == OP_WRITE && req_space == SP_DATA;
  assign wr_mask_en = req_valid && req_op == OP_WRITE && req_space == SP_MASK;
  assign rd_req     = req_valid && req_op == OP_READ;
  assign srch_en    = req_valid && req_op == OP_SEARCH;

  tma_ctrl_regs #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .NUM_GM(NUM_GM), .NUM_SLOT(NUM_SLOT),
    .ADDR_W(ADDR_W), .NFA_W(NFA_W), .GSEL_W(GSEL_W), .SLOT_W(SLOT_W), .KEY_W(KEY_W)
  ) u_ctrl (
    .clk, .rst_n, .req_valid, .req_op, .req_space, .req_addr, .req_wdata, .req_key,
    .req_gm_sel, .req_slot, .width_sh, .srch_gmask, .learn_en, .learn_base,
    .learn_key, .learn_done, .learn_err, .reg_rdata
  );

  tma_seg_store #(
    .SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W), .KEY_W(KEY_W)
  ) u_store (
    .clk, .rst_n, .wr_data_en, .wr_mask_en, .wr_addr(req_addr), .wr_word(req_wdata),
    .learn_en, .learn_base, .learn_key, .width_sh, .rd_mask_sel(req_space == SP_MASK),
    .rd_word(store_rd), .srch_en, .srch_key(req_key), .srch_gmask,
    .seg_hit_q(seg_hit), .seg_hit_vld(seg_vld)
  );

  tma_match_resolve #(
    .NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)
  ) u_resolve (
    .clk, .rst_n, .seg_hit, .seg_vld, .width_sh, .srch_valid, .srch_hit, .srch_index
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        case (req_space)
          SP_DATA, SP_MASK: rd_data <= store_rd;
          SP_REG:           rd_data <= reg_rdata;
          default:          rd_data <= '0;
        endcase
      end
    end
  end

  // R2: read data one cycle after the request
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R7: search result two cycles after the request
  a_r7_search_latency: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> ##1 srch_valid);
  // R7: no result without a search two cycles earlier
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    srch_valid |-> $past(srch_en, 2));

endmodule

// File: tb/ternary_match_array_tb.sv
module ternary_match_array_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [1:0]   req_op = '0, req_space = '0, req_gm_sel = '0;
  logic [3:0]   req_addr = '0, req_slot = '0;
  logic [71:0]  req_wdata = '0;
  logic [287:0] req_key = '0;
  logic         rd_valid, srch_valid, srch_hit, learn_done, learn_err;
  logic [71:0]  rd_data;
  logic [3:0]   srch_index;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ternary_match_array u_dut (
    .clk, .rst_n, .req_valid, .req_op, .req_space, .req_addr, .req_wdata, .req_key,
    .req_gm_sel, .req_slot, .rd_valid, .rd_data, .srch_valid, .srch_hit, .srch_index,
    .learn_done, .learn_err
  );

  function automatic logic [71:0] pat(int j);
    return {8'(j * 29 + 3), 32'(j) * 32'h9E3779B1, 32'hC0DE0000 ^ 32'(j * 771)};
  endfunction

  function automatic logic [287:0] ekey(int first, int k);
    logic [287:0] r = '0;
    for (int p = 0; p < k; p++) r[72*p +: 72] = pat(first + p);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [287:0] act, input logic [287:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] op, input logic [1:0] sp, input logic [3:0] a,
                     input logic [71:0] wd, input logic [287:0] k, input logic [1:0] gs,
                     input logic [3:0] sl);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_space = sp; req_addr = a;
    req_wdata = wd; req_key = k; req_gm_sel = gs; req_slot = sl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sp, input logic [3:0] a, input logic [71:0] wd);
    put(2'd0, sp, a, wd, '0, 2'd0, 4'd0);
  endtask

  task automatic rd(input logic [1:0] sp, input logic [3:0] a, output logic [71:0] d);
    put(2'd1, sp, a, '0, '0, 2'd0, 4'd0);
    chk(rd_valid === 1'b1, "R2 rd_valid", 288'(rd_valid), 288'(1));
    d = rd_data;
  endtask

  task automatic srch(input logic [287:0] k, input logic [1:0] gs, input logic [3:0] sl,
                      output logic h, output logic [3:0] ix);
    put(2'd2, 2'd0, 4'd0, '0, k, gs, sl);
    chk(srch_valid === 1'b0, "R7 not yet valid", 288'(srch_valid), 288'(0));
    @(negedge clk);
    chk(srch_valid === 1'b1, "R7 valid at two cycles", 288'(srch_valid), 288'(1));
    h = srch_hit;
    ix = srch_index;
  endtask

  task automatic expect_hit(input logic [287:0] k, input logic [1:0] gs, input bit eh,
                            input int eix, input string tag);
    logic h;
    logic [3:0] ix;
    srch(k, gs, 4'd0, h, ix);
    if (eh) chk(h === 1'b1 && ix === 4'(eix), tag, {283'(0), h, ix}, {283'(0), 1'b1, 4'(eix)});
    else    chk(h === 1'b0, tag, 288'(h), 288'(0));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [71:0] d;
    logic h;
    logic [3:0] ix;
    int cfgs [4];
    cfgs = '{0, 'h5555, 'hAAAA, 'h1234};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk(rd_valid === 0 && srch_valid === 0 && learn_done === 0 && learn_err === 0,
        "R1 outputs low", {rd_valid, srch_valid, learn_done, learn_err}, 288'(0));
    rd(2'd2, 4'd0, d); chk(d === 72'(0), "R1 width reg", 288'(d), 288'(0));
    rd(2'd2, 4'd1, d); chk(d === 72'(0), "R1 next-free", 288'(d), 288'(0));
    for (int g = 0; g < 4; g++) begin
      rd(2'd2, 4'(2 + g), d); chk(d === '1, "R1 global mask ones", 288'(d), 288'({72{1'b1}}));
    end
    expect_hit(ekey(0, 1), 2'd0, 1'b0, 0, "R1 no hit after reset");

    // R2: fill and read back every segment
    for (int j = 0; j < 16; j++) begin
      wr(2'd0, 4'(j), pat(j));
      wr(2'd1, 4'(j), '1);
    end
    for (int j = 0; j < 16; j++) begin
      rd(2'd0, 4'(j), d); chk(d === pat(j), "R2 data readback", 288'(d), 288'(pat(j)));
      rd(2'd1, 4'(j), d); chk(d === '1, "R2 mask readback", 288'(d), 288'({72{1'b1}}));
    end

    // R3 R4 R6 R7: every entry at every width
    for (int c = 0; c < 4; c++) begin
      int k;
      k = (cfgs[c] == 'h5555) ? 2 : (cfgs[c] == 'hAAAA) ? 4 : 1;
      wr(2'd2, 4'd0, 72'(cfgs[c]));
      rd(2'd2, 4'd0, d); chk(d === 72'(cfgs[c]), "R3 width readback", 288'(d), 288'(cfgs[c]));
      for (int e = 0; e < 16 / k; e++)
        expect_hit(ekey(e * k, k), 2'd0, 1'b1, e, "R4 R6 entry found at width");
    end

    // R5: global and local masks
    wr(2'd2, 4'd0, 72'(0));
    wr(2'd2, 4'd5, ~72'hFF);
    rd(2'd2, 4'd5, d); chk(d === ~72'hFF, "R3 global mask readback", 288'(d), 288'(~72'hFF));
    expect_hit(288'(pat(5) ^ 72'hFF), 2'd3, 1'b1, 5, "R5 global mask ignores bits");
    expect_hit(288'(pat(5) ^ 72'hFF), 2'd0, 1'b0, 0, "R5 full global mask compares");
    wr(2'd1, 4'd9, ~72'hF0);
    expect_hit(288'(pat(9) ^ 72'hF0), 2'd0, 1'b1, 9, "R5 local mask ignores bits");
    expect_hit(288'(pat(9) ^ 72'h100), 2'd0, 1'b0, 0, "R5 local mask keeps others");
    wr(2'd1, 4'd9, '1);

    // R6: wide entries need every lane in place
    wr(2'd2, 4'd0, 72'h5555);
    expect_hit({144'(0), pat(5) ^ 72'h1, pat(4)}, 2'd0, 1'b0, 0, "R6 one lane wrong");
    expect_hit({144'(0), pat(4), pat(5)}, 2'd0, 1'b0, 0, "R6 lanes swapped");
    wr(2'd2, 4'd0, 72'hAAAA);
    expect_hit(ekey(8, 4) ^ {72'h1, 216'(0)}, 2'd0, 1'b0, 0, "R6 top lane wrong");

    // R7: lowest entry wins
    wr(2'd2, 4'd0, 72'(0));
    wr(2'd0, 4'd12, pat(3));
    expect_hit(288'(pat(3)), 2'd0, 1'b1, 3, "R7 lowest of two");
    wr(2'd0, 4'd3, pat(30));
    expect_hit(288'(pat(3)), 2'd0, 1'b1, 12, "R7 only remaining");
    wr(2'd2, 4'd0, 72'h5555);
    wr(2'd0, 4'd14, pat(0));
    wr(2'd0, 4'd15, pat(1));
    expect_hit(ekey(0, 2), 2'd0, 1'b1, 0, "R7 lowest wide entry");

    // R8: invalid segments never match
    do_reset();
    expect_hit(288'(pat(6)), 2'd0, 1'b0, 0, "R8 stale data after reset");
    wr(2'd1, 4'd7, '1);
    expect_hit(288'(pat(7)), 2'd0, 1'b0, 0, "R8 mask write does not validate");
    wr(2'd0, 4'd6, pat(6));
    expect_hit(288'(pat(6)), 2'd0, 1'b1, 6, "R8 data write validates");

    // R9 R10 R11: learn through comparand slots
    wr(2'd2, 4'd0, 72'hAAAA);
    for (int i = 0; i < 4; i++) begin
      srch(ekey(40 + 4 * i, 4), 2'd0, 4'(3 + 4 * i), h, ix);
    end
    for (int i = 0; i < 4; i++) begin
      put(2'd3, 2'd0, 4'd0, '0, '0, 2'd0, 4'(3 + 4 * i));
      chk(learn_done === 1'b1 && learn_err === 1'b0, "R10 learn accepted",
          {learn_done, learn_err}, 288'(2));
      rd(2'd2, 4'd1, d); chk(d === 72'(4 * (i + 1)), "R10 next-free advances", 288'(d), 288'(4 * (i + 1)));
      expect_hit(ekey(40 + 4 * i, 4), 2'd0, 1'b1, i, "R9 R10 learned key found");
      rd(2'd1, 4'(4 * i + 1), d); chk(d === '1, "R10 learned mask ones", 288'(d), 288'({72{1'b1}}));
      rd(2'd0, 4'(4 * i + 2), d);
      chk(d === pat(40 + 4 * i + 2), "R10 learned lane data", 288'(d), 288'(pat(40 + 4 * i + 2)));
    end
    put(2'd3, 2'd0, 4'd0, '0, '0, 2'd0, 4'd3);
    chk(learn_err === 1'b1 && learn_done === 1'b0, "R11 learn rejected when full",
        {learn_done, learn_err}, 288'(1));
    rd(2'd2, 4'd1, d); chk(d === 72'(16), "R11 next-free unchanged", 288'(d), 288'(16));
    rd(2'd0, 4'd0, d); chk(d === pat(40), "R11 no write on reject", 288'(d), 288'(pat(40)));
    expect_hit(ekey(40, 4), 2'd0, 1'b1, 0, "R11 first entry intact");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule